// File: doc/BRIEF.md
# User-Mode SPI Flash Access Port

This block connects a processor bus to one or more serial flash chips. Software treats the flash as a raw SPI device. A small register file holds one control word per chip and a configuration word. A data window port turns bus loads and stores of one to four bytes into SPI byte transfers on the chip that the request selects. The transfers take place only when that chip is set to raw (user) access.

Each chip-select line is wired straight to a bit of that chip's control word. Software lowers the select, pushes the command, address and data bytes through the data window, and then raises the select again. Multi-byte accesses go out one byte at a time, lowest byte first. A store reaches the flash only when the chip's write-enable bit in the configuration word is set. A load from a chip that is not in raw mode returns all ones and produces no bus activity.

Top module: `spi_user_port`

## Requirements
- R1: After reset the configuration word (register word 0) reads 0, the status word (word 1) reads 0x00000800 (bit 11, transfer-done, set), every chip control word (word 4+i) reads 0x00000004, and every spi_cs_n line is 1.
- R2: spi_cs_n[i] always equals bit 2 of chip i's control word and changes only when a register write to that word is accepted.
- R3: A chip control word stores all 32 written bits: bits [1:0] hold the access mode (0 normal read, 1 fast read, 2 program, 3 raw), bit 2 is the select-stop bit, and bits [23:16] hold a command byte. Writes to the status word are ignored. Unmapped words read 0.
- R4: A raw-mode window read of N = win_size+1 bytes performs N SPI byte transfers, each sending 0x00. The first byte received lands in win_rdata[7:0], the next in [15:8], and so on. Bytes above N read 0.
- R5: A raw-mode window write of N bytes with the chip's enable bit set sends win_wdata[7:0] first, then the bytes above it in ascending order.
- R6: A window write to chip i while configuration bit 16+i is clear is dropped: no SCLK edge occurs and win_ready still pulses.
- R7: A window read from a chip whose mode is not 3 returns 0xFFFFFFFF and no SCLK edge occurs.
- R8: A window write to a chip whose mode is not 3 is dropped, even when its enable bit is set.
- R9: Each byte is shifted most significant bit first in SPI mode 0. SCLK idles low, its period is CLK_DIV system clocks, MOSI changes on the falling edge, and MISO is sampled on the rising edge.
- R10: win_ready and reg_ready are single-cycle pulses. The requester holds its request until ready. A window access that transfers bytes takes at least N*8*CLK_DIV cycles.
- R11: A register access that arrives while a window transfer is running completes only after that transfer has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, held until reg_ready |
| reg_we | input | 1 | 1 for a register write |
| reg_addr | input | REG_AW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_ready |
| reg_ready | output | 1 | Register access done pulse |
| win_req | input | 1 | Data window request, held until win_ready |
| win_we | input | 1 | 1 for a window store |
| win_cs | input | CSW | Chip index of the access |
| win_size | input | 2 | Byte count minus one |
| win_wdata | input | 32 | Store data, low byte sent first |
| win_rdata | output | 32 | Load data, valid with win_ready |
| win_ready | output | 1 | Window access done pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
A corrupted control word appears on spi_cs_n in the same cycle, and a register readback exposes it at once. A wrong mode or enable decode shows up as SCLK activity on an access that should have been dropped, or as its absence on one that should run. The bench counts the flash-side bytes to catch this in the access where it happens. A byte counter or shift register that slips shows up as misordered bytes in win_rdata, or on the flash-side log, by the end of the access in which it slips. A sequencer stuck busy holds back reg_ready and win_ready indefinitely.

// File: rtl/spi_user_pkg.sv
package spi_user_pkg;
   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_FAST   = 2'd1,
      MODE_PROG   = 2'd2,
      MODE_RAW    = 2'd3
   } access_mode_e;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   localparam int CTRL_STOP_BIT   = 2;
   localparam int CFG_WE_BASE     = 16;
   localparam int STATUS_DONE_BIT = 11;
   localparam int WORD_CFG        = 0;
   localparam int WORD_STATUS     = 1;
   localparam int WORD_CTRL_BASE  = 4;
endpackage

// File: rtl/spi_user_regs.sv
module spi_user_regs
   import spi_user_pkg::*;
#(
   parameter int NUM_CS = 2,
   parameter int REG_AW = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc,
   input  logic                   we,
   input  logic [REG_AW-1:0]      addr,
   input  logic [31:0]            wdata,
   output logic [31:0]            rd_data,
   output logic [31:0]            cfg,
   output logic [NUM_CS-1:0][31:0] ctrl
);
   localparam logic [31:0] STATUS_VAL  = 32'(1) << STATUS_DONE_BIT;
   localparam logic [31:0] CTRL_RESET  = 32'(1) << CTRL_STOP_BIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg <= '0;
      else if (acc && we && addr == REG_AW'(WORD_CFG))
         cfg <= wdata;
   end

   for (genvar i = 0; i < NUM_CS; i++) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctrl[i] <= CTRL_RESET;
         else if (acc && we && addr == REG_AW'(WORD_CTRL_BASE + i))
            ctrl[i] <= wdata;
      end
   end

   always_comb begin
      rd_data = '0;
      if (addr == REG_AW'(WORD_CFG))    rd_data = cfg;
      if (addr == REG_AW'(WORD_STATUS)) rd_data = STATUS_VAL;
      for (int i = 0; i < NUM_CS; i++)
         if (addr == REG_AW'(WORD_CTRL_BASE + i)) rd_data = ctrl[i];
   end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
   parameter int CLK_DIV = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx_byte,
   output logic       sclk,
   output logic       mosi
);
   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;
   logic [2:0]    bit_cnt;
   logic [7:0]    tx_sh;
   logic [7:0]    rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done    <= 1'b0;
         cnt     <= '0;
         bit_cnt <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
         sclk    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy    <= 1'b1;
            tx_sh   <= tx_byte;
            bit_cnt <= 3'd7;
            cnt     <= '0;
            sclk    <= 1'b0;
         end else if (busy) begin
            if (cnt == CW'(HALF - 1)) begin
               cnt <= '0;
               if (!sclk) begin
                  sclk  <= 1'b1;
                  rx_sh <= {rx_sh[6:0], miso};
               end else begin
                  sclk <= 1'b0;
                  if (bit_cnt == 3'd0) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bit_cnt <= bit_cnt - 3'd1;
                     tx_sh   <= {tx_sh[6:0], 1'b0};
                  end
               end
            end else begin
               cnt <= cnt + CW'(1);
            end
         end
      end
   end

   assign mosi    = tx_sh[7];
   assign rx_byte = rx_sh;
endmodule

// File: rtl/spi_user_port.sv
module spi_user_port
   import spi_user_pkg::*;
#(
   parameter int NUM_CS  = 2,
   parameter int CLK_DIV = 4,
   parameter int REG_AW  = 4,
   localparam int CSW    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_req,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              reg_ready,
   input  logic              win_req,
   input  logic              win_we,
   input  logic [CSW-1:0]    win_cs,
   input  logic [1:0]        win_size,
   input  logic [31:0]       win_wdata,
   output logic [31:0]       win_rdata,
   output logic              win_ready,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs_n
);
   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("CLK_DIV must be even and at least 2");
   end
   if (NUM_CS < 1 || NUM_CS > 16) begin : g_bad_cs
      $error("NUM_CS must be between 1 and 16");
   end
   if (WORD_CTRL_BASE + NUM_CS > (1 << REG_AW)) begin : g_bad_aw
      $error("REG_AW too small for the control words");
   end

   logic [31:0]             cfg;
   logic [NUM_CS-1:0][31:0] ctrl;
   logic [31:0]             rd_mux;
   logic                    reg_take;
   logic                    win_take;
   logic [31:0]             sel_ctrl;
   logic                    sel_we_en;
   logic [1:0]              sel_mode;
   logic                    go;
   seq_state_e              state;
   logic                    seq_busy;
   logic [1:0]              byte_idx;
   logic [1:0]              last_idx;
   logic                    we_q;
   logic [31:0]             wdata_q;
   logic                    sh_start;
   logic                    sh_busy;
   logic                    sh_done;
   logic [7:0]              sh_rx;

   assign seq_busy = (state == SEQ_RUN);
   assign reg_take = reg_req && !reg_ready && !seq_busy;
   assign win_take = win_req && !win_ready && !seq_busy && !reg_take;

   spi_user_regs #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc     (reg_take),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rd_data (rd_mux),
      .cfg     (cfg),
      .ctrl    (ctrl)
   );

   always_comb begin
      sel_ctrl  = '0;
      sel_we_en = 1'b0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (win_cs == CSW'(i)) begin
            sel_ctrl  = ctrl[i];
            sel_we_en = cfg[CFG_WE_BASE + i];
         end
      end
   end

   assign sel_mode = sel_ctrl[1:0];
   assign go = (access_mode_e'(sel_mode) == MODE_RAW) && (!win_we || sel_we_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_ready <= 1'b0;
         reg_rdata <= '0;
      end else begin
         reg_ready <= reg_take;
         if (reg_take) reg_rdata <= rd_mux;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         byte_idx  <= '0;
         last_idx  <= '0;
         we_q      <= 1'b0;
         wdata_q   <= '0;
         win_rdata <= '0;
         win_ready <= 1'b0;
         sh_start  <= 1'b0;
      end else begin
         win_ready <= 1'b0;
         sh_start  <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               if (win_take) begin
                  if (go) begin
                     state     <= SEQ_RUN;
                     byte_idx  <= '0;
                     last_idx  <= win_size;
                     we_q      <= win_we;
                     wdata_q   <= win_wdata;
                     win_rdata <= '0;
                     sh_start  <= 1'b1;
                  end else begin
                     win_ready <= 1'b1;
                     win_rdata <= '1;
                  end
               end
            end
            SEQ_RUN: begin
               if (sh_done) begin
                  if (!we_q) win_rdata[{byte_idx, 3'b000} +: 8] <= sh_rx;
                  wdata_q <= wdata_q >> 8;
                  if (byte_idx == last_idx) begin
                     win_ready <= 1'b1;
                     state     <= SEQ_IDLE;
                  end else begin
                     byte_idx <= byte_idx + 2'd1;
                     sh_start <= 1'b1;
                  end
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sh_start),
      .tx_byte (we_q ? wdata_q[7:0] : 8'h00),
      .miso    (spi_miso),
      .busy    (sh_busy),
      .done    (sh_done),
      .rx_byte (sh_rx),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi)
   );

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign spi_cs_n[i] = ctrl[i][CTRL_STOP_BIT];
   end
endmodule

// File: rtl/spi_user_port_chk.sv
module spi_user_port_chk #(
   parameter int NUM_CS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_take,
   input logic              reg_ready,
   input logic              seq_busy,
   input logic              win_req,
   input logic              win_we,
   input logic              win_ready,
   input logic [31:0]       win_rdata,
   input logic [1:0]        sel_mode,
   input logic              spi_sclk,
   input logic [NUM_CS-1:0] spi_cs_n
);
   // R2: a select line moves only after an accepted register access
   assert_cs_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_cs_n != $past(spi_cs_n)) |-> $past(reg_take));

   // R10: window completion is a single-cycle pulse
   assert_win_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      win_ready |=> !win_ready);

   // R10: register completion is a single-cycle pulse
   assert_reg_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_ready |=> !reg_ready);

   // R9: serial clock has returned low when an access completes
   assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      win_ready |-> !spi_sclk);

   // R7: loads from a chip outside raw mode return all ones
   assert_nonraw_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (win_ready && !win_we && sel_mode != 2'd3) |-> (&win_rdata));

   // R11: a register access never completes out of a running transfer
   assert_reg_waits_R11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_ready |-> !$past(seq_busy));

   // R6: no serial clock without an outstanding window request
   assert_sclk_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !win_req |-> !spi_sclk);
endmodule

bind spi_user_port spi_user_port_chk #(.NUM_CS(NUM_CS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_take  (reg_take),
   .reg_ready (reg_ready),
   .seq_busy  (seq_busy),
   .win_req   (win_req),
   .win_we    (win_we),
   .win_ready (win_ready),
   .win_rdata (win_rdata),
   .sel_mode  (sel_mode),
   .spi_sclk  (spi_sclk),
   .spi_cs_n  (spi_cs_n)
);

// File: tb/spi_user_port_bench.sv
`timescale 1ns/1ps
module spi_user_port_bench;
   localparam int NUM_CS  = 2;
   localparam int CLK_DIV = 4;
   localparam int REG_AW  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_req = 1'b0, reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_ready;
   logic        win_req = 1'b0, win_we = 1'b0;
   logic [0:0]  win_cs = '0;
   logic [1:0]  win_size = '0;
   logic [31:0] win_wdata = '0;
   logic [31:0] win_rdata;
   logic        win_ready;
   logic        spi_sclk, spi_mosi;
   logic        spi_miso = 1'b0;
   logic [1:0]  spi_cs_n;

   int vectors = 0;
   int miscompares = 0;
   int cyc = 0;

   spi_user_port #(.NUM_CS(NUM_CS), .CLK_DIV(CLK_DIV), .REG_AW(REG_AW)) u_spi_user_port (
      .clk(clk), .rst_n(rst_n),
      .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .reg_ready(reg_ready),
      .win_req(win_req), .win_we(win_we), .win_cs(win_cs), .win_size(win_size),
      .win_wdata(win_wdata), .win_rdata(win_rdata), .win_ready(win_ready),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         miscompares++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   function automatic logic [7:0] resp_byte(input int k);
      return 8'((k * 29 + 7) % 256);
   endfunction

   function automatic logic [31:0] exp_read(input int base, input int n);
      logic [31:0] v = '0;
      for (int j = 0; j < n; j++) v[j*8 +: 8] = resp_byte(base + j);
      return v;
   endfunction

   // flash-side model: mode 0, MSB first
   int          slv_bytes = 0;
   int          slv_bits = 0;
   logic [7:0]  slv_rx = '0;
   logic [7:0]  slv_tx;
   logic [7:0]  sent_log [256];
   time         t_last = 0, t_per = 0;

   initial begin
      slv_tx   = resp_byte(0);
      spi_miso = slv_tx[7];
   end

   always @(posedge spi_sclk) begin
      slv_rx = {slv_rx[6:0], spi_mosi};
      slv_bits++;
      t_per  = $time - t_last;
      t_last = $time;
   end

   always @(negedge spi_sclk) begin
      if (slv_bits == 8) begin
         sent_log[slv_bytes % 256] = slv_rx;
         slv_bytes++;
         slv_bits = 0;
         slv_tx   = resp_byte(slv_bytes);
         spi_miso = slv_tx[7];
      end else begin
         spi_miso = slv_tx[7 - slv_bits];
      end
   end

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic reg_acc(input logic we, input int addr, input logic [31:0] wd,
                          output logic [31:0] rd);
      @(negedge clk);
      reg_req = 1'b1; reg_we = we; reg_addr = 4'(addr); reg_wdata = wd;
      do @(negedge clk); while (!reg_ready);
      rd = reg_rdata;
      reg_req = 1'b0; reg_we = 1'b0;
   endtask

   task automatic win_acc(input logic we, input int cs, input int n, input logic [31:0] wd,
                          output logic [31:0] rd, output int cycles);
      @(negedge clk);
      win_req = 1'b1; win_we = we; win_cs = 1'(cs); win_size = 2'(n - 1); win_wdata = wd;
      cycles = 0;
      do begin @(negedge clk); cycles++; end while (!win_ready);
      rd = win_rdata;
      win_req = 1'b0; win_we = 1'b0;
   endtask

   logic [31:0] rd;
   int          cycles, base;
   int          t_win, t_reg;
   logic [31:0] cfg_m;
   logic [31:0] ctrl_m [2];

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 cs_n after reset", 32'(spi_cs_n), 32'h3);
      rst_n = 1'b1;
      reg_acc(1'b0, 0, 0, rd); check("R1 config reset", rd, 32'h0);
      reg_acc(1'b0, 1, 0, rd); check("R1 status reset", rd, 32'h800);
      reg_acc(1'b0, 4, 0, rd); check("R1 ctrl0 reset", rd, 32'h4);
      reg_acc(1'b0, 5, 0, rd); check("R1 ctrl1 reset", rd, 32'h4);
      reg_acc(1'b0, 2, 0, rd); check("R3 unmapped word", rd, 32'h0);

      // R2 / R3: select control and field storage
      reg_acc(1'b1, 4, 32'h00AB_0003, rd);
      check("R2 cs0 low after stop cleared", 32'(spi_cs_n), 32'h2);
      reg_acc(1'b0, 4, 0, rd); check("R3 ctrl0 readback", rd, 32'h00AB_0003);
      reg_acc(1'b1, 1, 32'h0, rd);
      reg_acc(1'b0, 1, 0, rd); check("R3 status write ignored", rd, 32'h800);

      // R4 / R9 / R10: raw read of four bytes
      base = slv_bytes;
      win_acc(1'b0, 0, 4, 32'h0, rd, cycles);
      check("R4 raw read data", rd, exp_read(base, 4));
      check("R4 byte count", 32'(slv_bytes - base), 32'd4);
      for (int j = 0; j < 4; j++)
         check("R4 dummy byte sent", 32'(sent_log[(base + j) % 256]), 32'h0);
      check("R10 latency floor", 32'(cycles >= 4 * 8 * CLK_DIV), 32'h1);
      check("R9 sclk period", 32'(t_per), 32'(CLK_DIV * 10));

      // R4: short read leaves upper bytes zero
      base = slv_bytes;
      win_acc(1'b0, 0, 2, 32'h0, rd, cycles);
      check("R4 two byte read", rd, exp_read(base, 2));

      // R6: write with enable clear
      base = slv_bytes;
      win_acc(1'b1, 0, 3, 32'h00C3_B2A1, rd, cycles);
      check("R6 disabled write dropped", 32'(slv_bytes - base), 32'd0);

      // R5: enabled write, low byte first
      reg_acc(1'b1, 0, 32'h0001_0000, rd);
      base = slv_bytes;
      win_acc(1'b1, 0, 3, 32'h00C3_B2A1, rd, cycles);
      check("R5 byte count", 32'(slv_bytes - base), 32'd3);
      check("R5 byte 0", 32'(sent_log[base % 256]), 32'hA1);
      check("R5 byte 1", 32'(sent_log[(base + 1) % 256]), 32'hB2);
      check("R5 byte 2", 32'(sent_log[(base + 2) % 256]), 32'hC3);

      // R7: read from non-raw chip
      base = slv_bytes;
      win_acc(1'b0, 1, 4, 32'h0, rd, cycles);
      check("R7 non-raw read ones", rd, 32'hFFFF_FFFF);
      check("R7 no transfer", 32'(slv_bytes - base), 32'd0);

      // R8: write to non-raw chip with enable set
      reg_acc(1'b1, 0, 32'h0003_0000, rd);
      reg_acc(1'b1, 5, 32'h0000_0002, rd);
      check("R2 cs1 low", 32'(spi_cs_n), 32'h0);
      base = slv_bytes;
      win_acc(1'b1, 1, 4, 32'h1234_5678, rd, cycles);
      check("R8 non-raw write dropped", 32'(slv_bytes - base), 32'd0);

      // R11: register access queued behind a transfer
      base = slv_bytes;
      fork
         begin
            logic [31:0] r1; int c1;
            win_acc(1'b0, 0, 4, 32'h0, r1, c1);
            t_win = cyc;
            check("R11 read during contention", r1, exp_read(base, 4));
         end
         begin
            logic [31:0] r2;
            repeat (6) @(negedge clk);
            reg_acc(1'b0, 4, 0, r2);
            t_reg = cyc;
            check("R11 readback value", r2, 32'h00AB_0003);
         end
      join
      check("R11 register after transfer", 32'(t_reg > t_win), 32'h1);

      reg_acc(1'b1, 4, 32'h0000_0007, rd);
      check("R2 cs0 deselected", 32'(spi_cs_n), 32'h1);

      // random mix
      cfg_m = 32'h0003_0000;
      ctrl_m[0] = 32'h7; ctrl_m[1] = 32'h2;
      for (int it = 0; it < 60; it++) begin
         int cs = $urandom_range(1, 0);
         int n  = $urandom_range(4, 1);
         logic wr = 1'($urandom_range(1, 0));
         logic [31:0] wd = $urandom;
         logic raw;
         logic [31:0] ex;
         ctrl_m[cs] = {8'h0, 8'($urandom), 13'h0, 1'($urandom_range(1, 0)),
                       2'($urandom_range(3, 0) | $urandom_range(3, 2))};
         cfg_m = 32'($urandom_range(3, 0)) << 16;
         reg_acc(1'b1, 4 + cs, ctrl_m[cs], rd);
         reg_acc(1'b1, 0, cfg_m, rd);
         check("R2 random cs_n", 32'(spi_cs_n), {30'h0, ctrl_m[1][2], ctrl_m[0][2]});
         raw = (ctrl_m[cs][1:0] == 2'd3);
         base = slv_bytes;
         win_acc(wr, cs, n, wd, rd, cycles);
         if (!wr) begin
            ex = raw ? exp_read(base, n) : 32'hFFFF_FFFF;
            check(raw ? "R4 random read" : "R7 random read", rd, ex);
            check(raw ? "R4 random count" : "R7 random count",
                  32'(slv_bytes - base), raw ? 32'(n) : 32'd0);
         end else if (raw && cfg_m[16 + cs]) begin
            check("R5 random count", 32'(slv_bytes - base), 32'(n));
            for (int j = 0; j < n; j++)
               check("R5 random byte", 32'(sent_log[(base + j) % 256]), 32'(wd[j*8 +: 8]));
         end else begin
            check(raw ? "R6 random dropped" : "R8 random dropped",
                  32'(slv_bytes - base), 32'd0);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule